// File: doc/BRIEF.md
# SRAM Sleep-Mode Power Controller

This block sequences a synchronous SRAM into and out of a low-power sleep state. The sleep request arrives on a pin that has no timing relation to the clock. The block passes it through a synchronizer and then counts a fixed number of clock cycles to enter sleep. When the request is removed, it counts a fixed recovery window before the memory can be used again. From the start of entry until recovery is over, the block holds an access-inhibit output high. The surrounding control logic uses that output to drop any access still in flight and to refuse new ones, so the array contents are never disturbed.

While asleep, a core power-down output tells the memory core it may drop to retention power. This output depends on the raw pin as well as the state. Power-down therefore ends at once, with no clock edge, when the pin goes low.

The block also polices the deselect rule around sleep. The device must not be selected when sleep is requested, and no chip enable or address strobe may be active during recovery. Either fault sets a violation flag, which stays set until reset.

Top module: `sram_sleep_ctrl`

## Requirements
- R1: The sleep request passes through `SYNC_STAGES` flip-flops. `access_inhibit` rises on the third rising clock edge after `sleep_req` goes high, and not before.
- R2: `sleep_active` rises `ENTRY_CYCLES` edges after `access_inhibit` rises. With the defaults, this is the fifth edge after the request.
- R3: `core_pwr_down` is high exactly when `sleep_active` is high and the raw `sleep_req` pin is high. It falls with no clock edge when the pin falls.
- R4: After `sleep_req` falls, `sleep_active` drops on the third edge. `access_inhibit` drops a further `EXIT_CYCLES` edges later, which is the fifth edge with the defaults.
- R5: `access_inhibit` stays high without a gap from the start of entry, through sleep, to the end of recovery.
- R6: If any bit of `chip_en` (1 = that enable asserted), `strobe_a` or `strobe_b` (1 = strobe active) is high on an edge inside the recovery window, `proto_violation` is set.
- R7: On the edge where the synchronized request is first seen, `proto_violation` is set if any of these holds:
  - the device is selected, meaning every bit of `chip_en` is 1;
  - `strobe_a` is high;
  - `strobe_b` is high.
  A partial set of enables at that edge does not set the flag.
- R8: Once set, `proto_violation` stays high until reset, whatever the inputs do.
- R9: While no sleep sequence is running, any activity on the enables and strobes leaves `proto_violation` and `access_inhibit` unchanged.
- R10: During and after reset, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sleep_req | input | 1 | Asynchronous sleep request, 1 = request sleep |
| chip_en | input | NUM_CE | Chip enables, 1 = that enable asserted |
| strobe_a | input | 1 | First address strobe, 1 = active |
| strobe_b | input | 1 | Second address strobe, 1 = active |
| sleep_active | output | 1 | High while in the sleep state |
| core_pwr_down | output | 1 | Retention-power request to the memory core |
| access_inhibit | output | 1 | Block and cancel accesses |
| proto_violation | output | 1 | Latched deselect-rule violation |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, two-cycle entry and recovery windows, and three chip enables. With these values, every edge from request to sleep and from release to the end of recovery can be sampled one at a time. Three enables make it possible to apply a partial select, which must be harmless at the request edge but is a fault during recovery. Random sleep lengths and random enable and strobe traffic while idle are mixed with directed fault cases, each of which is cleared by reset.

// File: rtl/sram_sleep_pkg.sv
package sram_sleep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ENTER   = 2'd1,
    ST_SLEEP   = 2'd2,
    ST_RECOVER = 2'd3
  } slp_state_e;
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import sram_sleep_pkg::*;
#(
  parameter int ENTRY_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_s,
  output slp_state_e state
);
  localparam int MAXC  = (ENTRY_CYCLES > EXIT_CYCLES) ? ENTRY_CYCLES : EXIT_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] ENT_LAST = CNT_W'(ENTRY_CYCLES - 1);
  localparam logic [CNT_W-1:0] EXT_LAST = CNT_W'(EXIT_CYCLES - 1);

  slp_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_s) begin
        state_d = ST_ENTER;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
      ST_ENTER: begin
        cnt_en = 1'b1;
        if (cnt_q == ENT_LAST) state_d = ST_SLEEP;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      ST_SLEEP: if (!req_s) begin
        state_d = ST_RECOVER;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
      ST_RECOVER: begin
        cnt_en = 1'b1;
        if (cnt_q == EXT_LAST) state_d = ST_IDLE;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/slp_viol_mon.sv
module slp_viol_mon
  import sram_sleep_pkg::*;
#(
  parameter int NUM_CE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slp_state_e        state,
  input  logic              req_s,
  input  logic [NUM_CE-1:0] chip_en,
  input  logic              strobe_a,
  input  logic              strobe_b,
  output logic              viol
);
  logic viol_q, viol_d, selected, any_act, bad_req, bad_rec;

  always_comb begin
    selected = &chip_en;
    any_act  = (|chip_en) | strobe_a | strobe_b;
    bad_req  = (state == ST_IDLE) & req_s & (selected | strobe_a | strobe_b);
    bad_rec  = (state == ST_RECOVER) & any_act;
    viol_d   = viol_q | bad_req | bad_rec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= viol_d;
  end

  assign viol = viol_q;
endmodule

// File: rtl/sram_sleep_ctrl.sv
module sram_sleep_ctrl
  import sram_sleep_pkg::*;
#(
  parameter int NUM_CE       = 3,
  parameter int SYNC_STAGES  = 2,
  parameter int ENTRY_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic [NUM_CE-1:0] chip_en,
  input  logic              strobe_a,
  input  logic              strobe_b,
  output logic              sleep_active,
  output logic              core_pwr_down,
  output logic              access_inhibit,
  output logic              proto_violation
);
  logic       rst_n_s;
  logic       req_s;
  slp_state_e state;

  slp_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_s)
  );

  slp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
    .clk(clk), .rst_n(rst_n_s), .d(sleep_req), .q(req_s)
  );

  slp_fsm #(.ENTRY_CYCLES(ENTRY_CYCLES), .EXIT_CYCLES(EXIT_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .req_s(req_s), .state(state)
  );

  slp_viol_mon #(.NUM_CE(NUM_CE)) u_viol (
    .clk(clk), .rst_n(rst_n_s), .state(state), .req_s(req_s),
    .chip_en(chip_en), .strobe_a(strobe_a), .strobe_b(strobe_b),
    .viol(proto_violation)
  );

  assign sleep_active   = (state == ST_SLEEP);
  assign core_pwr_down  = (state == ST_SLEEP) & sleep_req;
  assign access_inhibit = (state != ST_IDLE);
endmodule

// File: rtl/sram_sleep_ctrl_chk.sv
module sram_sleep_ctrl_chk #(
  parameter int NUM_CE = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_req,
  input logic [NUM_CE-1:0] chip_en,
  input logic              strobe_a,
  input logic              strobe_b,
  input logic              sleep_active,
  input logic              core_pwr_down,
  input logic              access_inhibit,
  input logic              proto_violation
);
  AST_PWRDN_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    core_pwr_down |-> (sleep_active && sleep_req));  // R3
  AST_SLEEP_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_active |-> access_inhibit);  // R5
  AST_SLEEP_AFTER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_active) |-> $past(access_inhibit));  // R2
  AST_INHIBIT_ENDS_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(access_inhibit) |-> !sleep_active);  // R4
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_violation |=> proto_violation);  // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !(sleep_active || core_pwr_down || access_inhibit || proto_violation));  // R10
endmodule

bind sram_sleep_ctrl sram_sleep_ctrl_chk #(.NUM_CE(NUM_CE)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .chip_en(chip_en),
  .strobe_a(strobe_a), .strobe_b(strobe_b), .sleep_active(sleep_active),
  .core_pwr_down(core_pwr_down), .access_inhibit(access_inhibit),
  .proto_violation(proto_violation)
);

// File: tb/sram_sleep_ctrl_bench.sv
module sram_sleep_ctrl_bench;
  localparam int NCE = 3;

  logic           clk;
  logic           rst_n;
  logic           sleep_req;
  logic [NCE-1:0] chip_en;
  logic           strobe_a, strobe_b;
  logic           sleep_active, core_pwr_down, access_inhibit, proto_violation;

  int  checks;
  int  failures;
  bit  done;
  bit  exp_viol;
  int  seed;

  sram_sleep_ctrl #(.NUM_CE(NCE)) u_sram_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .chip_en(chip_en),
    .strobe_a(strobe_a), .strobe_b(strobe_b), .sleep_active(sleep_active),
    .core_pwr_down(core_pwr_down), .access_inhibit(access_inhibit),
    .proto_violation(proto_violation)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic bit req_edge_bad(logic [NCE-1:0] ce, logic sa, logic sb);
    return (&ce) | sa | sb;
  endfunction

  function automatic bit recov_bad(logic [NCE-1:0] ce, logic sa, logic sb);
    return (|ce) | sa | sb;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic quiet();
    chip_en  = '0;
    strobe_a = 1'b0;
    strobe_b = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n     = 1'b0;
    sleep_req = 1'b0;
    quiet();
    step();
    chk("R10 inhibit", access_inhibit, 1'b0);
    chk("R10 viol", proto_violation, 1'b0);
    chk("R10 sleep", sleep_active, 1'b0);
    chk("R10 pwr", core_pwr_down, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
    exp_viol = 1'b0;
  endtask

  task automatic sleep_cycle(int hold, logic [NCE-1:0] req_ce, logic req_sa,
                             logic [NCE-1:0] rec_ce, logic rec_sa, logic rec_sb);
    @(negedge clk);
    sleep_req = 1'b1;
    chip_en   = req_ce;
    strobe_a  = req_sa;
    step();
    chk("R1 edge1", access_inhibit, 1'b0);
    step();
    chk("R1 edge2", access_inhibit, 1'b0);
    step();
    chk("R1 edge3", access_inhibit, 1'b1);
    chk("R2 not yet", sleep_active, 1'b0);
    exp_viol = exp_viol | req_edge_bad(req_ce, req_sa, 1'b0);
    chk("R7 request edge", proto_violation, exp_viol);
    @(negedge clk);
    quiet();
    step();
    chk("R2 edge4", sleep_active, 1'b0);
    chk("R5 entry", access_inhibit, 1'b1);
    step();
    chk("R2 edge5", sleep_active, 1'b1);
    chk("R3 pwr on", core_pwr_down, 1'b1);
    for (int i = 0; i < hold; i++) begin
      step();
      chk("R5 asleep", access_inhibit, 1'b1);
      chk("R3 hold", core_pwr_down, 1'b1);
    end
    @(negedge clk);
    sleep_req = 1'b0;
    #1;
    chk("R3 immediate off", core_pwr_down, 1'b0);
    chk("R4 still asleep", sleep_active, 1'b1);
    step();
    step();
    chk("R4 edge2", sleep_active, 1'b1);
    step();
    chk("R4 edge3", sleep_active, 1'b0);
    chk("R5 recovery", access_inhibit, 1'b1);
    @(negedge clk);
    chip_en  = rec_ce;
    strobe_a = rec_sa;
    strobe_b = rec_sb;
    step();
    chk("R4 edge4", access_inhibit, 1'b1);
    step();
    chk("R4 edge5", access_inhibit, 1'b0);
    exp_viol = exp_viol | recov_bad(rec_ce, rec_sa, rec_sb);
    chk("R6 recovery", proto_violation, exp_viol);
    @(negedge clk);
    quiet();
  endtask

  task automatic idle_traffic(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chip_en  = NCE'($urandom);
      strobe_a = 1'($urandom);
      strobe_b = 1'($urandom);
      step();
      chk("R9 viol", proto_violation, exp_viol);
      chk("R9 inhibit", access_inhibit, 1'b0);
    end
    @(negedge clk);
    quiet();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0; exp_viol = 1'b0;
    seed = $urandom(32'h5EED_0A1B);
    rst_n = 1'b0; sleep_req = 1'b0;
    quiet();
    do_reset();

    sleep_cycle(3, '0, 1'b0, '0, 1'b0, 1'b0);
    idle_traffic(20);
    sleep_cycle(0, 3'b011, 1'b0, '0, 1'b0, 1'b0);  // R7 partial select harmless
    chk("R7 partial", proto_violation, 1'b0);

    sleep_cycle(2, 3'b111, 1'b0, '0, 1'b0, 1'b0);  // R7 selected
    idle_traffic(10);
    chk("R8 sticky", proto_violation, 1'b1);
    do_reset();

    sleep_cycle(1, '0, 1'b1, '0, 1'b0, 1'b0);      // R7 strobe
    do_reset();
    sleep_cycle(1, '0, 1'b0, 3'b100, 1'b0, 1'b0);  // R6 one enable
    do_reset();
    sleep_cycle(1, '0, 1'b0, '0, 1'b0, 1'b1);      // R6 strobe b
    do_reset();
    sleep_cycle(1, '0, 1'b0, '0, 1'b1, 1'b0);      // R6 strobe a
    do_reset();

    for (int k = 0; k < 30; k++) begin
      logic [NCE-1:0] rce;
      rce = ($urandom % 4 == 0) ? NCE'($urandom) : '0;
      sleep_cycle(int'($urandom % 6), '0, 1'b0, rce, 1'b0, 1'b0);
      idle_traffic(int'($urandom % 5) + 1);
      if (exp_viol) do_reset();
    end
    finish_run();
  end
endmodule